// File: doc/BRIEF.md
# Programmable Serial Test-Pattern Generator

This block produces one test bit per enabled clock for bit error rate measurement. A 32-stage shift register runs in one of three configurations. A pseudo-random configuration feeds back the XOR of two selectable stages. A repeating-word configuration rotates a loaded word of selectable length. A fixed-polynomial configuration with zero-run suppression overrides every other field.

Software sets a 16-bit configuration word and a 32-bit seed. The seed is presented as two 16-bit halves. A load strobe copies the seed into the shift register, and from then on each `bitEn` cycle advances the pattern by one bit. The output is combinational from internal state and the current configuration word.

Stage numbering used below: stage k (1 to 32) is seed bit k-1, and `seedLo` bit 0 is stage 1. On every shift, stage k+1 takes the old stage k, and the feedback bit enters stage 1.

Top module: `bertPatternGen`

## Requirements
- R1: After reset the shift register and the look-ahead window are all zero, and with the all-zero configuration word `patBit` reads 0.
- R2: When `loadStb` is high at a clock edge, the shift register takes {`seedHi`,`seedLo`}; this has priority over `bitEn`. In the non-override configurations, `patBit` then shows seed bit n-1.
- R3: With `loadStb` and `bitEn` both low, no state changes, so `patBit` holds its value while the configuration word is unchanged.
- R4: In pseudo-random configuration (word bit 5 = 0, bit 6 = 0), the feedback is stage n XOR stage y. Here n = word[4:0]+1 and y = word[12:8]+1. With n=7, y=6 and a non-zero seed, the output repeats every 127 bits and carries 64 ones per period.
- R5: In repeating-word configuration (word bit 5 = 1, bit 6 = 0), the feedback is stage n alone and word[12:8] has no effect. The output cycles through seed bits n-1 down to 0.
- R6: Outside the override, `patBit` is stage n.
- R7: Only word bits 12:8 (tap), 6 (override), 5 (type) and 4:0 (length) have meaning. Bits 15:13 and 7 are ignored.
- R8: With word bit 6 = 1, the generator uses x^20 + x^17 + 1 (feedback stage 20 XOR stage 17). Word bits 5, 4:0 and 12:8 are ignored.
- R9: A load in override mode ignores the seed inputs and loads 32'h000F_FFFF, so the generator cannot stall at all zeros.
- R10: In override mode, the raw stage-20 bits pass through a 14-bit window cleared on load. `patBit` is the oldest window bit, forced to 1 when all 14 window bits are zero. The forced value is never fed back, and no run of zeros on `patBit` exceeds 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWord | input | 16 | Pattern configuration word |
| seedLo | input | 16 | Seed bits 15:0 |
| seedHi | input | 16 | Seed bits 31:16 |
| loadStb | input | 1 | Copy seed into shift register |
| bitEn | input | 1 | Advance pattern by one bit |
| patBit | output | 1 | Generated test bit |

## Verification
A wrong feedback tap or length stage shows up at `patBit` within a few bits of the first shift. It then keeps the sequence from ever repeating with the expected period, or from holding the expected ones count. A corrupted look-ahead window shows after exactly 14 enabled bits in override mode, because that is when window contents reach the output. A shift taken without `bitEn` shows on the very next sample. Comparing every clock against a behavioural model therefore exposes each fault within one period of the pattern at most.

// File: rtl/bertGenPkg.sv
package bertGenPkg;
  localparam int SR_W  = 32;
  localparam int IDX_W = $clog2(SR_W);
  localparam int CFG_W = 16;

  typedef struct packed {
    logic             load;
    logic             shift;
    logic             qrss;
    logic             repeatMode;
    logic [IDX_W-1:0] lenIdx;
    logic [IDX_W-1:0] tapIdx;
  } genStrb_t;
endpackage

// File: rtl/bertGenCtrl.sv
module bertGenCtrl
  import bertGenPkg::*;
#(
  parameter int Q_LEN = 20,
  parameter int Q_TAP = 17
) (
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             loadStb,
  input  logic             bitEn,
  output genStrb_t         strb
);
  // field positions are decoded by software; keep them fixed
  localparam int LEN_LSB  = 0;
  localparam int TYPE_BIT = 5;
  localparam int OVR_BIT  = 6;
  localparam int TAP_LSB  = 8;

  logic             ovrSel;
  logic [IDX_W-1:0] userLen;
  logic [IDX_W-1:0] userTap;

  assign ovrSel  = cfgWord[OVR_BIT];
  assign userLen = cfgWord[LEN_LSB +: IDX_W];
  assign userTap = cfgWord[TAP_LSB +: IDX_W];

  always_comb begin
    strb.load       = loadStb;
    strb.shift      = bitEn & ~loadStb;
    strb.qrss       = ovrSel;
    strb.repeatMode = ~ovrSel & cfgWord[TYPE_BIT];
    strb.lenIdx     = ovrSel ? IDX_W'(Q_LEN - 1) : userLen;
    strb.tapIdx     = ovrSel ? IDX_W'(Q_TAP - 1) : userTap;
  end
endmodule

// File: rtl/bertGenPath.sv
module bertGenPath
  import bertGenPkg::*;
#(
  parameter int              WIN    = 14,
  parameter int              Q_LEN  = 20,
  parameter logic [SR_W-1:0] Q_SEED = 32'h000F_FFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  genStrb_t        strb,
  input  logic [SR_W-1:0] seedWord,
  output logic            patBit
);
  logic [SR_W-1:0] srQ;
  logic [WIN-1:0]  dlyQ;
  logic            lenBit;
  logic            tapBit;
  logic            fbBit;
  logic            coreBit;
  logic            zeroWin;

  assign lenBit  = srQ[strb.lenIdx];
  assign tapBit  = srQ[strb.tapIdx];
  assign fbBit   = strb.repeatMode ? lenBit : (lenBit ^ tapBit);
  assign coreBit = srQ[Q_LEN-1];
  assign zeroWin = (dlyQ == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srQ  <= '0;
      dlyQ <= '0;
    end else if (strb.load) begin
      srQ  <= strb.qrss ? Q_SEED : seedWord;
      dlyQ <= '0;
    end else if (strb.shift) begin
      srQ  <= {srQ[SR_W-2:0], fbBit};
      dlyQ <= {dlyQ[WIN-2:0], coreBit};
    end
  end

  assign patBit = strb.qrss ? (zeroWin | dlyQ[WIN-1]) : lenBit;

  p_load_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && !strb.qrss) |=> (srQ == $past(seedWord)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.load && !strb.shift) |=> ($stable(srQ) && $stable(dlyQ)));

  p_shift_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shift |=> (srQ[SR_W-1:1] == $past(srQ[SR_W-2:0])));

  p_fixed_seed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && strb.qrss) |=> (srQ == Q_SEED));

  p_raw_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.shift |=> (dlyQ[0] == $past(srQ[Q_LEN-1])));
endmodule

// File: rtl/bertPatternGen.sv
module bertPatternGen
  import bertGenPkg::*;
#(
  parameter int              WIN    = 14,
  parameter int              Q_LEN  = 20,
  parameter int              Q_TAP  = 17,
  parameter logic [SR_W-1:0] Q_SEED = 32'h000F_FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfgWord,
  input  logic [SR_W/2-1:0]  seedLo,
  input  logic [SR_W/2-1:0]  seedHi,
  input  logic               loadStb,
  input  logic               bitEn,
  output logic               patBit
);
  genStrb_t strb;

  bertGenCtrl #(.Q_LEN(Q_LEN), .Q_TAP(Q_TAP)) ctrl_i (
    .cfgWord(cfgWord),
    .loadStb(loadStb),
    .bitEn  (bitEn),
    .strb   (strb)
  );

  bertGenPath #(.WIN(WIN), .Q_LEN(Q_LEN), .Q_SEED(Q_SEED)) path_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .seedWord({seedHi, seedLo}),
    .patBit  (patBit)
  );
endmodule

// File: tb/bertPatternGen_tb_top.sv
`timescale 1ns/1ps
module bertPatternGen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfgWord = '0;
  logic [15:0] seedLo = '0;
  logic [15:0] seedHi = '0;
  logic        loadStb = 1'b0;
  logic        bitEn = 1'b0;
  logic        patBit;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  logic [31:0] mSr = '0;
  bit          mDly[$];
  bit          hist[$];

  always #4 clk = ~clk;

  bertPatternGen dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWord(cfgWord), .seedLo(seedLo),
    .seedHi(seedHi), .loadStb(loadStb), .bitEn(bitEn), .patBit(patBit)
  );

  task automatic chk(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", t, act, exp);
    end
  endtask

  task automatic clearWin();
    mDly.delete();
    for (int i = 0; i < 14; i++) mDly.push_back(1'b0);
  endtask

  function automatic bit expOut();
    bit allZero;
    if (cfgWord[6]) begin
      allZero = 1'b1;
      foreach (mDly[i]) if (mDly[i]) allZero = 1'b0;
      return allZero ? 1'b1 : mDly[0];
    end
    return mSr[cfgWord[4:0]];
  endfunction

  task automatic modelClock();
    bit fb;
    bit lenB;
    if (loadStb) begin
      mSr = cfgWord[6] ? 32'h000F_FFFF : {seedHi, seedLo};
      clearWin();
    end else if (bitEn) begin
      if (cfgWord[6]) fb = mSr[19] ^ mSr[16];
      else begin
        lenB = mSr[cfgWord[4:0]];
        fb = cfgWord[5] ? lenB : (lenB ^ mSr[cfgWord[12:8]]);
      end
      mDly.push_back(mSr[19]);
      void'(mDly.pop_front());
      mSr = {mSr[30:0], fb};
    end
  endtask

  task automatic cyc(input bit ld, input bit en);
    loadStb = ld;
    bitEn = en;
    @(posedge clk);
    modelClock();
    @(negedge clk);
    chk(tag, patBit, expOut());
    hist.push_back(patBit);
  endtask

  initial begin
    clearWin();
    repeat (3) @(negedge clk);
    chk("R1 reset", patBit, 1'b0);
    rst_n = 1'b1;
    tag = "R1";
    cyc(0, 0);
    cyc(0, 1);
    chk("R1 idle after reset", patBit, 1'b0);

    // R4: n=7, y=6, seed 1
    cfgWord = 16'h0506; seedLo = 16'h0001; seedHi = 16'h0000;
    tag = "R4 model"; hist.delete();
    cyc(1, 0);
    for (int i = 0; i < 300; i++) cyc(0, 1);
    for (int i = 0; i + 127 < hist.size(); i++)
      chk("R4 period 127", hist[i+127], hist[i]);
    begin
      int ones = 0;
      for (int i = 10; i < 137; i++) ones += hist[i];
      checks++;
      if (ones != 64) begin
        errors++;
        $display("FAIL R4 ones per period actual=%0d expected=64", ones);
      end
    end

    // R3: no enable, no load
    tag = "R3 model";
    begin
      logic held;
      held = patBit;
      for (int i = 0; i < 6; i++) begin
        cyc(0, 0);
        chk("R3 hold", patBit, held);
      end
    end

    // R5 and R6: repeating word, n=8, seed A5, tap field set
    cfgWord = 16'h0327; seedLo = 16'h00A5; tag = "R5 model"; hist.delete();
    cyc(1, 1);
    for (int i = 0; i < 23; i++) begin
      if (i == 10) cfgWord = 16'h1D27;  // change tap field mid-run
      cyc(0, 1);
    end
    for (int k = 0; k < 24; k++)
      chk("R5 R6 rotate", hist[k], seedLo[7 - (k % 8)]);

    // R7: undefined bits set
    cfgWord = 16'hE0A7; tag = "R7 model"; hist.delete();
    cyc(1, 0);
    for (int i = 0; i < 15; i++) cyc(0, 1);
    for (int k = 0; k < 16; k++)
      chk("R7 spare bits", hist[k], seedLo[7 - (k % 8)]);

    // R2: top stage
    cfgWord = 16'h001F; seedHi = 16'h8000; seedLo = 16'h0000; tag = "R2 model";
    cyc(1, 1);
    chk("R2 load top stage", patBit, 1'b1);
    cyc(0, 1);
    chk("R2 after shift", patBit, 1'b0);
    for (int i = 0; i < 40; i++) cyc(0, 1);

    // R8, R9, R10: override with zero seed regs
    cfgWord = 16'h0040; seedHi = 16'h0000; seedLo = 16'h0000;
    tag = "R8 R10 model"; hist.delete();
    cyc(1, 0);
    chk("R10 forced after load", patBit, 1'b1);
    for (int i = 0; i < 13; i++) cyc(0, 1);
    chk("R10 raw zero before window fills", patBit, 1'b0);
    cyc(0, 1);
    chk("R10 first core bit after 14", patBit, 1'b1);
    for (int i = 0; i < 3000; i++) cyc(0, 1);
    begin
      bit runA[$];
      int run = 0;
      int maxRun = 0;
      int ones = 0;
      runA = hist;
      foreach (runA[i]) begin
        ones += runA[i];
        run = runA[i] ? 0 : run + 1;
        if (run > maxRun) maxRun = run;
      end
      checks++;
      if (maxRun > 14) begin
        errors++;
        $display("FAIL R10 zero run actual=%0d expected<=14", maxRun);
      end
      checks++;
      if (ones < 100 || ones > runA.size() - 100) begin
        errors++;
        $display("FAIL R9 not stalled actual=%0d ones expected mixed", ones);
      end
      // R8, R9: junk fields and seed make no difference
      cfgWord = 16'hFFFF; seedHi = 16'h1234; seedLo = 16'h5678;
      tag = "R8 R9 model"; hist.delete();
      cyc(1, 0);
      for (int i = 0; i < 400; i++) begin
        if (i == 200) cfgWord = 16'h0061;
        cyc(0, 1);
      end
      for (int i = 0; i < 401; i++)
        chk("R8 R9 override sequence", hist[i], runA[i]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule